// File: doc/BRIEF.md
# Store-Multiple Address Sequencer

This block turns one store-multiple request into a paced train of single-word memory writes. A request carries a 16-bit mask of registers, a 32-bit base address, the index of the register that holds the base, and three control bits: a direction bit (`up_i`), a timing bit (`pre_i`) and a writeback bit (`wb_i`). The direction bit chooses between addresses above and below the base. The timing bit chooses whether the base is stepped before or after each transfer.

The sequencer reduces all four addressing modes to one rising walk over consecutive words. Each write beat names the register to fetch and the address to write. It also carries a source code. The code tells the surrounding datapath whether to take the data from the register file or from the side value `wr_alt_o`. The side value is the original base, the stepped base, or the instruction address plus the pipeline offset. When the walk is over, the block raises a one-cycle done pulse together with the new base value and a writeback enable.

The register file, the memory and the instruction decoder are outside this block.

Top module: `mstore_walker`

## Requirements
- R1: A request is taken on a clock edge where `start_i` is high and `busy_o` is low. `busy_o` is high from the next cycle through the done cycle inclusive. While `busy_o` is high, `start_i` and the request inputs are ignored: no beat or done of the running request changes. After reset, `busy_o`, `wr_valid_o`, `done_o` and `wb_en_o` are low.
- R2: While `wr_valid_o` is high and `wr_ready_i` is low, the beat stays up with unchanged address, register index and source code.
- R3: Each set bit of the mask produces exactly one beat. Beats come in ascending register index order, and each accepted beat is followed by one whose address is 4 higher. A non-contiguous mask still gives consecutive word addresses.
- R4: With N set bits and A the aligned base, the first beat address is set by the mode:
  - `up_i`=1, `pre_i`=0: A
  - `up_i`=1, `pre_i`=1: A+4
  - `up_i`=0, `pre_i`=1: A−4N
  - `up_i`=0, `pre_i`=0: A−4N+4
- R5: `done_o` is high for exactly one cycle, the cycle after the last accepted beat. In that cycle:
  - `wb_value_o` equals base+4N when `up_i`=1 and base−4N when `up_i`=0, computed on the full base value.
  - `wb_en_o` equals the registered `wb_i`.
  - `wb_en_o` is never high outside a done cycle.
- R6: An all-zero mask produces no beat. `done_o` is high in the cycle right after the request is taken, and `wb_value_o` then equals the base unchanged.
- R7: `wr_src_o` codes are:
  - 0: data from the register file.
  - 1: original base, which appears on `wr_alt_o`.
  - 2: stepped base (the writeback value), which appears on `wr_alt_o`.
  - 3: program counter, with `pc_i`+12 on `wr_alt_o`.
- R8: A beat for the base register carries code 1 when the base register is the lowest set bit of the mask, or when `wb_i` is 0. It carries code 2 when `wb_i` is 1 and the base register is not the lowest set bit.
- R9: A beat for register 15 always carries code 3 with `pc_i`+12 on `wr_alt_o`, even when 15 is also the base index.
- R10: Bits [1:0] of the base are ignored for addressing: every beat address has bits [1:0] equal to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request strobe, taken when idle |
| reg_mask_i | input | 16 | Selected registers, bit i for register i |
| base_i | input | 32 | Base address value |
| base_idx_i | input | 4 | Index of the register holding the base |
| up_i | input | 1 | 1 = addresses above base, 0 = below |
| pre_i | input | 1 | 1 = step before transfer, 0 = after |
| wb_i | input | 1 | Request base writeback |
| pc_i | input | 32 | Address of the store instruction |
| busy_o | output | 1 | Request in progress |
| wr_valid_o | output | 1 | Write beat present |
| wr_ready_i | input | 1 | Memory accepts the current beat |
| wr_addr_o | output | 32 | Word address of the beat |
| wr_reg_o | output | 4 | Register index of the beat |
| wr_src_o | output | 2 | Data source code (see R7) |
| wr_alt_o | output | 32 | Substitute store value for codes 1 to 3 |
| done_o | output | 1 | One-cycle completion pulse |
| wb_en_o | output | 1 | Write the new base back (done cycle only) |
| wb_value_o | output | 32 | New base value |

## Verification
The embedded properties assume three things about the surrounding logic:
- `wr_ready_i` is a plain level that the memory side may hold low for any length of time.
- Requests arrive only as single-cycle `start_i` strobes.
- Nothing but reset interrupts a walk.

The bench respects all three. A pseudo-random pattern with long runs of stalls drives the ready line, and each request is issued only after `busy_o` has fallen. The single exception is a deliberate strobe in the middle of a long walk, whose only purpose is to show that it is ignored. Base values stay far from the ends of the address space, so no beat address wraps past zero.

// File: rtl/mstore_pkg.sv
package mstore_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_FIN  = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        SRC_FILE     = 2'd0,
        SRC_OLD_BASE = 2'd1,
        SRC_NEW_BASE = 2'd2,
        SRC_PC       = 2'd3
    } src_e;

endpackage

// File: rtl/mstore_lowbit.sv
// Lowest-set-bit finder: returns the index of the lowest 1 in vec_i.
module mstore_lowbit #(
    parameter int W  = 16,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec_i,
    output logic [IW-1:0] idx_o,
    output logic          any_o
);
    logic [W:0]   seen;
    logic [W-1:0] hit;

    assign seen[0] = 1'b0;

    for (genvar g = 0; g < W; g++) begin : g_chain
        assign seen[g+1] = seen[g] | vec_i[g];
        assign hit[g]    = vec_i[g] & ~seen[g];
    end

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < W; i++) begin
            if (hit[i]) idx_o = idx_o | IW'(i);
        end
    end

    assign any_o = seen[W];
endmodule

// File: rtl/mstore_plan.sv
// Start-of-request arithmetic: beat count, first word address, stepped base.
module mstore_plan #(
    parameter int REGS = 16,
    parameter int AW   = 32,
    parameter int CW   = $clog2(REGS + 1)
) (
    input  logic [REGS-1:0] mask_i,
    input  logic [AW-1:0]   base_i,
    input  logic            up_i,
    input  logic            pre_i,
    output logic [CW-1:0]   count_o,
    output logic [AW-1:0]   first_addr_o,
    output logic [AW-1:0]   new_base_o
);
    localparam int WORD_SHIFT = 2;

    logic [AW-1:0] span;
    logic [AW-1:0] aligned;

    always_comb begin
        count_o = '0;
        for (int i = 0; i < REGS; i++) begin
            count_o = count_o + CW'(mask_i[i]);
        end
    end

    assign span    = AW'(count_o) << WORD_SHIFT;
    assign aligned = {base_i[AW-1:WORD_SHIFT], {WORD_SHIFT{1'b0}}};

    always_comb begin
        unique case ({up_i, pre_i})
            2'b10:   first_addr_o = aligned;
            2'b11:   first_addr_o = aligned + AW'(4);
            2'b01:   first_addr_o = aligned - span;
            default: first_addr_o = aligned - span + AW'(4);
        endcase
    end

    assign new_base_o = up_i ? (base_i + span) : (base_i - span);
endmodule

// File: rtl/mstore_walker.sv
module mstore_walker #(
    parameter int REGS   = 16,
    parameter int AW     = 32,
    parameter int PC_OFS = 12,
    localparam int IW    = $clog2(REGS),
    localparam int CW    = $clog2(REGS + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [REGS-1:0] reg_mask_i,
    input  logic [AW-1:0]   base_i,
    input  logic [IW-1:0]   base_idx_i,
    input  logic            up_i,
    input  logic            pre_i,
    input  logic            wb_i,
    input  logic [AW-1:0]   pc_i,
    output logic            busy_o,
    output logic            wr_valid_o,
    input  logic            wr_ready_i,
    output logic [AW-1:0]   wr_addr_o,
    output logic [IW-1:0]   wr_reg_o,
    output logic [1:0]      wr_src_o,
    output logic [AW-1:0]   wr_alt_o,
    output logic            done_o,
    output logic            wb_en_o,
    output logic [AW-1:0]   wb_value_o
);
    import mstore_pkg::*;

    localparam logic [IW-1:0] PC_IDX = IW'(REGS - 1);

    typedef struct packed {
        phase_e          ph;
        logic [REGS-1:0] left;
        logic [AW-1:0]   addr;
        logic [AW-1:0]   old_base;
        logic [AW-1:0]   new_base;
        logic [AW-1:0]   pc_adj;
        logic [IW-1:0]   base_idx;
        logic            base_first;
        logic            wb;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    // request-side arithmetic
    logic [CW-1:0] plan_count;
    logic [AW-1:0] plan_first;
    logic [AW-1:0] plan_new_base;
    logic [IW-1:0] req_low_idx;
    logic          req_low_any;

    mstore_plan #(.REGS(REGS), .AW(AW), .CW(CW)) u_plan (
        .mask_i       (reg_mask_i),
        .base_i       (base_i),
        .up_i         (up_i),
        .pre_i        (pre_i),
        .count_o      (plan_count),
        .first_addr_o (plan_first),
        .new_base_o   (plan_new_base)
    );

    mstore_lowbit #(.W(REGS), .IW(IW)) u_req_low (
        .vec_i (reg_mask_i),
        .idx_o (req_low_idx),
        .any_o (req_low_any)
    );

    // walk-side: next register still pending
    logic [IW-1:0] cur_idx;
    logic          cur_any;

    mstore_lowbit #(.W(REGS), .IW(IW)) u_cur_low (
        .vec_i (ctl_q.left),
        .idx_o (cur_idx),
        .any_o (cur_any)
    );

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    ctl_d.left       = reg_mask_i;
                    ctl_d.addr       = plan_first;
                    ctl_d.old_base   = base_i;
                    ctl_d.new_base   = plan_new_base;
                    ctl_d.pc_adj     = pc_i + AW'(PC_OFS);
                    ctl_d.base_idx   = base_idx_i;
                    ctl_d.base_first = req_low_any && (req_low_idx == base_idx_i);
                    ctl_d.wb         = wb_i;
                    ctl_d.ph         = (plan_count != '0) ? PH_RUN : PH_FIN;
                end
            end
            PH_RUN: begin
                if (wr_ready_i && cur_any) begin
                    ctl_d.left[cur_idx] = 1'b0;
                    ctl_d.addr          = ctl_q.addr + AW'(4);
                    if (ctl_d.left == '0) ctl_d.ph = PH_FIN;
                end
            end
            PH_FIN: begin
                ctl_d.ph = PH_IDLE;
            end
            default: ctl_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{ph: PH_IDLE, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // beat source selection
    logic [1:0]    src_sel;
    logic [AW-1:0] alt_val;

    always_comb begin
        if (cur_idx == PC_IDX) begin
            src_sel = SRC_PC;
            alt_val = ctl_q.pc_adj;
        end else if (cur_idx == ctl_q.base_idx) begin
            if (ctl_q.wb && !ctl_q.base_first) begin
                src_sel = SRC_NEW_BASE;
                alt_val = ctl_q.new_base;
            end else begin
                src_sel = SRC_OLD_BASE;
                alt_val = ctl_q.old_base;
            end
        end else begin
            src_sel = SRC_FILE;
            alt_val = '0;
        end
    end

    assign busy_o     = (ctl_q.ph != PH_IDLE);
    assign wr_valid_o = (ctl_q.ph == PH_RUN);
    assign wr_addr_o  = ctl_q.addr;
    assign wr_reg_o   = cur_idx;
    assign wr_src_o   = src_sel;
    assign wr_alt_o   = alt_val;
    assign done_o     = (ctl_q.ph == PH_FIN);
    assign wb_en_o    = done_o && ctl_q.wb;
    assign wb_value_o = ctl_q.new_base;

    // embedded checks
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!wr_valid_o && !done_o)) else $error("idle outputs active"); // R1

    AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_addr_o)
                                         && $stable(wr_reg_o) && $stable(wr_src_o)))
        else $error("stalled beat changed"); // R2

    AST_WORD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && wr_ready_i) |=> (!wr_valid_o || (wr_addr_o == $past(wr_addr_o) + AW'(4))))
        else $error("address not consecutive"); // R3

    AST_REG_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && wr_ready_i) |=> (!wr_valid_o || (wr_reg_o > $past(wr_reg_o))))
        else $error("register order not ascending"); // R3

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o) else $error("done longer than one cycle"); // R5

    AST_WB_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en_o |-> done_o) else $error("writeback outside done"); // R5

    AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |-> (wr_addr_o[1:0] == 2'b00)) else $error("unaligned beat"); // R10
endmodule

// File: tb/tb_mstore_walker.sv
module tb_mstore_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] mask = '0;
    logic [31:0] base = '0;
    logic [3:0]  bidx = '0;
    logic        up = 1'b0, pre = 1'b0, wb = 1'b0;
    logic [31:0] pc = '0;
    logic        rdy = 1'b1;
    logic        busy, wv, done, wben;
    logic [31:0] waddr, walt, wbval;
    logic [3:0]  wreg;
    logic [1:0]  wsrc;

    always #5 clk = ~clk;

    mstore_walker dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .reg_mask_i(mask),
        .base_i(base), .base_idx_i(bidx), .up_i(up), .pre_i(pre), .wb_i(wb),
        .pc_i(pc), .busy_o(busy), .wr_valid_o(wv), .wr_ready_i(rdy),
        .wr_addr_o(waddr), .wr_reg_o(wreg), .wr_src_o(wsrc), .wr_alt_o(walt),
        .done_o(done), .wb_en_o(wben), .wb_value_o(wbval)
    );

    typedef struct {
        logic [31:0] addr;
        logic [3:0]  rg;
        logic [1:0]  src;
        logic [31:0] alt;
        string       atag;
    } beat_t;

    typedef struct {
        logic        en;
        logic [31:0] val;
    } fin_t;

    beat_t exp_q[$];
    fin_t  fin_q[$];
    int    n_run = 0, n_fail = 0;
    bit    finished = 1'b0;
    bit    always_rdy = 1'b1;
    logic [7:0] lfsr = 8'hA5;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // ready pattern, changed just after each rising edge
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        rdy  = always_rdy ? 1'b1 : (lfsr[0] & lfsr[3]);
    end

    // monitor / scoreboard
    bit          stall_pend = 1'b0;
    logic [31:0] h_addr;
    logic [3:0]  h_reg;
    logic [1:0]  h_src;

    always @(negedge clk) begin
        if (rst_n) begin
            if (stall_pend) begin
                chk(wv && waddr == h_addr && wreg == h_reg && wsrc == h_src,
                    "R2 held beat", {waddr[27:0], wreg}, {h_addr[27:0], h_reg});
            end
            stall_pend = 1'b0;
            if (wv) begin
                if (rdy) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R1/R3 unexpected beat", {28'h0, wreg}, 32'h0);
                    end else begin
                        beat_t e;
                        e = exp_q.pop_front();
                        chk(waddr == e.addr, e.atag, waddr, e.addr);
                        chk(wreg == e.rg, "R3 register order", {28'h0, wreg}, {28'h0, e.rg});
                        chk(wsrc == e.src, "R7 source code", {30'h0, wsrc}, {30'h0, e.src});
                        if (e.src != 2'd0)
                            chk(walt == e.alt, (e.src == 2'd3) ? "R9 pc value" : "R8 base value",
                                walt, e.alt);
                    end
                end else begin
                    stall_pend = 1'b1;
                    h_addr = waddr; h_reg = wreg; h_src = wsrc;
                end
            end
            if (done) begin
                chk(exp_q.size() == 0, "R5 done before last beat", exp_q.size(), 0);
                if (fin_q.size() == 0) begin
                    chk(1'b0, "R5 unexpected done", 32'h1, 32'h0);
                end else begin
                    fin_t f;
                    f = fin_q.pop_front();
                    chk(wben == f.en, "R5 writeback enable", {31'h0, wben}, {31'h0, f.en});
                    chk(wbval == f.val, "R5 writeback value", wbval, f.val);
                end
            end else begin
                chk(!wben, "R5 enable outside done", {31'h0, wben}, 32'h0);
            end
        end
    end

    // driver: computes expectations from the requirements, then issues the request
    task automatic run_op(input logic [15:0] m, input logic [31:0] b, input logic [3:0] ix,
                          input bit u, input bit p, input bit w, input logic [31:0] pcv,
                          input bit poke);
        int          n = $countones(m);
        logic [31:0] a = b & ~32'h3;
        logic [31:0] nb = u ? b + 32'(4 * n) : b - 32'(4 * n);
        logic [31:0] cur;
        int          low = -1;
        bit          first = 1'b1;
        for (int i = 0; i < 16; i++) if (m[i] && low < 0) low = i;
        if (u) cur = p ? a + 32'd4 : a;
        else   cur = p ? a - 32'(4 * n) : a - 32'(4 * n) + 32'd4;
        for (int i = 0; i < 16; i++) begin
            if (m[i]) begin
                beat_t e;
                e.addr = cur;
                e.rg   = 4'(i);
                e.alt  = 32'h0;
                e.src  = 2'd0;
                if (i == 15) begin
                    e.src = 2'd3; e.alt = pcv + 32'd12;
                end else if (i == int'(ix)) begin
                    if (w && i != low) begin e.src = 2'd2; e.alt = nb; end
                    else begin e.src = 2'd1; e.alt = b; end
                end
                e.atag = first ? ((b[1:0] != 2'b00) ? "R10 first address" : "R4 first address")
                               : "R3 consecutive address";
                first = 1'b0;
                exp_q.push_back(e);
                cur = cur + 32'd4;
            end
        end
        begin
            fin_t f;
            f.en = w; f.val = nb;
            fin_q.push_back(f);
        end
        @(negedge clk);
        while (busy) @(negedge clk);
        mask = m; base = b; bidx = ix; up = u; pre = p; wb = w; pc = pcv;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy, "R1 busy after start", {31'h0, busy}, 32'h1);
        if (m == 16'h0) begin
            chk(done && !wv, "R6 empty list done next cycle", {30'h0, done, wv}, 32'h2);
        end
        if (poke) begin
            @(negedge clk);
            mask = 16'h00F0; base = 32'h4000; bidx = 4'd2; up = 1'b0; wb = 1'b0;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (busy) @(negedge clk);
        chk(exp_q.size() == 0 && fin_q.size() == 0, "R1 request completed once",
            exp_q.size() + fin_q.size(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL R1 watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !wv && !done && !wben, "R1 reset state",
            {28'h0, busy, wv, done, wben}, 32'h0);

        // increment-after, 14 regs, base register 14 outside list
        run_op(16'h3FFF, 32'h800, 4'd14, 1'b1, 1'b0, 1'b1, 32'h100, 1'b0);
        // increment-before, same list, with stalls
        always_rdy = 1'b0;
        run_op(16'h3FFF, 32'h800, 4'd14, 1'b1, 1'b1, 1'b1, 32'h100, 1'b0);
        // single base register in own list: old base stored
        run_op(16'h4000, 32'h800, 4'd14, 1'b1, 1'b1, 1'b1, 32'h100, 1'b0);
        // decrement-after, {r14, r15}, no writeback, pc substitution
        run_op(16'hC000, 32'h800, 4'd0, 1'b0, 1'b0, 1'b0, 32'h2C4, 1'b0);
        // decrement-before, {r0, r9, r10}, base r9 not lowest: new base
        run_op(16'h0601, 32'h800, 4'd9, 1'b0, 1'b1, 1'b1, 32'h100, 1'b0);
        // same list, no writeback: old base
        run_op(16'h0601, 32'h900, 4'd9, 1'b0, 1'b1, 1'b0, 32'h100, 1'b0);
        // base register is lowest of several: old base
        run_op(16'h0A08, 32'h1000, 4'd3, 1'b1, 1'b0, 1'b1, 32'h100, 1'b0);
        // empty list with writeback
        run_op(16'h0000, 32'h1234, 4'd1, 1'b1, 1'b0, 1'b1, 32'h100, 1'b0);
        // misaligned base, decrement-after
        run_op(16'h0111, 32'h2003, 4'd7, 1'b0, 1'b0, 1'b1, 32'h100, 1'b0);
        // base index 15 collides with pc slot: pc wins
        run_op(16'h8002, 32'h3000, 4'd15, 1'b1, 1'b1, 1'b1, 32'h500, 1'b0);
        // full list, decrement-before, mid-walk start strobe must be ignored
        run_op(16'hFFFF, 32'h8000, 4'd5, 1'b0, 1'b1, 1'b1, 32'h700, 1'b1);
        // increment-after with ready always high, base in middle
        always_rdy = 1'b1;
        run_op(16'h5555, 32'h6000, 4'd6, 1'b1, 1'b0, 1'b1, 32'h100, 1'b0);

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule